// File: doc/BRIEF.md
# Double-Buffered Single-Shot DMA Channel

This block is one peripheral-to-memory DMA channel with two complete descriptor sets. Each set holds a start address, a word count and a command word. At any moment one set is the active one. The hardware works through the active set while software fills in the other set. When the active set runs out of words, the channel moves straight to the other set, but only if software has armed it. A set never restarts by itself: once its count reaches zero it stays disarmed until software arms it again.

Data words arrive from the peripheral over a valid/ready handshake. Each word is written to memory through a simple request/acknowledge port, one word at a time. After each acknowledged word the address advances by one word and the count drops by one. When a set completes, a sticky done flag is set. This flag drives the interrupt line until software clears it by writing a one. A single control register holds a channel enable. Clearing the enable aborts the transfer in progress and disarms both sets. The block is parameterised in address, count and data width, so it can be placed once per peripheral.

Top module: `pp_dma_channel`

## Requirements
- R1: After reset, irq, memReq and perReady are 0, the control word (index 8) reads 0 and both command words read 0.
- R2: The register port is word indexed. The address, count and command of set 0 sit at indexes 0, 1 and 2 (byte offsets 0x0, 0x4, 0x8). Set 1 sits at indexes 4, 5 and 6 (0x10 above). The control word sits at index 8. Address and count read back their live values. Command bit 0 reads back the armed state. Control bits are: bit 0 enable, bit 1 done, bit 2 busy, bit 3 active-set index.
- R3: Writing a command word with bit 0 set arms that set only if its count is non-zero. Writing bit 0 clear disarms it. Arming with a zero count leaves the set disarmed.
- R4: A word is taken from the peripheral when perValid and perReady are both high. In a later cycle memReq rises with memAddr equal to the set's current address and memWData equal to that word. After memAck, the address grows by DATA_W/8 and the count falls by one.
- R5: When the count of the active set reaches zero, that set is disarmed, and the done bit and irq become 1.
- R6: If the other set is armed when the active one completes, control passes to it with perReady high in the very next cycle, and the active-set index changes.
- R7: If the other set is not armed at completion, the channel goes idle (busy 0, perReady 0). It starts again as soon as any set is armed.
- R8: Done and irq stay set until a control write with bit 1 set. A control write with bit 1 clear leaves them set.
- R9: Writes to the address, count or command of the active set are ignored while that set is armed. The inactive set accepts writes at any time.
- R10: A control write with bit 0 clear disarms both sets and drops memReq and perReady from the next cycle on, without stepping the count.
- R11: The channel handles one word at a time: perReady is low whenever memReq is high.
- R12: While enable is 0, no transfer starts even if a set is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regIdx | input | 4 | Register word index |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regIdx |
| perValid | input | 1 | Peripheral offers a word |
| perData | input | DATA_W | Peripheral word |
| perReady | output | 1 | Channel accepts a word |
| memReq | output | 1 | Memory write request |
| memAddr | output | ADDR_W | Memory byte address |
| memWData | output | DATA_W | Memory write data |
| memAck | input | 1 | Memory accepted the write |
| irq | output | 1 | Completion interrupt, sticky |

## Verification
A table of four transfers alternates between the two sets. The transfers use different start addresses, lengths of one to four words and distinct data seeds. The table shows whether each word lands at the right address with the right data, and one entry crosses a 64 KiB boundary to expose carry faults in the address counter. Each table transfer ends with the other set unarmed, so it exercises the idle path. A directed run with both sets armed shows whether the hand-over happens without a dead cycle. Further directed runs cover a write to the busy set, an abort while a memory write is pending, zero-length arming, and arming while the channel is disabled. Each of these is checked only through the register readback and the handshake outputs.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_PER,
    ST_WRITE_MEM
  } chanState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic flip;      // swap active set
    logic capture;   // latch peripheral word
    logic step;      // advance address, count down
    logic complete;  // disarm active set, set done
  } dpStrobe_t;

  localparam int REG_IW = 4;
  localparam logic [REG_IW-1:0] CTL_IDX = 4'd8;

endpackage

// File: rtl/pp_dma_ctrl.sv
module pp_dma_ctrl
  import pp_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      abort,
  input  logic      armedAct,
  input  logic      armedOth,
  input  logic      lastWord,
  input  logic      perValid,
  input  logic      memAck,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      perReady,
  output logic      memReq
);

  chanState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (enable && !abort) begin
          if (armedAct) begin
            nextState = ST_WAIT_PER;
          end else if (armedOth) begin
            strobe.flip = 1'b1;
            nextState   = ST_WAIT_PER;
          end
        end
      end
      ST_WAIT_PER: begin
        if (abort || !enable) begin
          nextState = ST_IDLE;
        end else if (perValid) begin
          strobe.capture = 1'b1;
          nextState      = ST_WRITE_MEM;
        end
      end
      ST_WRITE_MEM: begin
        if (abort) begin
          nextState = ST_IDLE;
        end else if (memAck) begin
          strobe.step = 1'b1;
          if (lastWord) begin
            strobe.complete = 1'b1;
            if (armedOth) begin
              strobe.flip = 1'b1;
              nextState   = ST_WAIT_PER;
            end else begin
              nextState = ST_IDLE;
            end
          end else begin
            nextState = ST_WAIT_PER;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign perReady = (state == ST_WAIT_PER) && !abort;
  assign memReq   = (state == ST_WRITE_MEM) && !abort;

  AST_FLIP_TO_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flip |-> armedOth);  // R6

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !busy);  // R12

endmodule

// File: rtl/pp_dma_datapath.sv
module pp_dma_datapath
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [REG_IW-1:0] regIdx,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [DATA_W-1:0] perData,
  input  dpStrobe_t         strobe,
  input  logic              busy,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic              armedAct,
  output logic              armedOth,
  output logic              lastWord,
  output logic              enable,
  output logic              abort,
  output logic              irq
);

  localparam int NUM_SETS   = 2;
  localparam int WORD_BYTES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ [NUM_SETS];
  logic [LEN_W-1:0]  lenQ  [NUM_SETS];
  logic [NUM_SETS-1:0] armedQ;
  logic              actSel;
  logic              doneQ;
  logic [DATA_W-1:0] dataQ;
  logic              ctlWr;

  assign ctlWr = regWr && (regIdx == CTL_IDX);
  assign abort = ctlWr && !regWrData[0];

  for (genvar s = 0; s < NUM_SETS; s++) begin : gen_set
    logic [ADDR_W-1:0] addrR;
    logic [LEN_W-1:0]  lenR;
    logic              armedR;
    logic              isAct;
    logic              selWr;
    logic              locked;

    assign isAct  = (actSel == s[0]);
    assign selWr  = regWr && !regIdx[3] && (regIdx[2] == s[0]);
    assign locked = armedR && isAct;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrR  <= '0;
        lenR   <= '0;
        armedR <= 1'b0;
      end else begin
        if (strobe.step && isAct) begin
          addrR <= addrR + ADDR_W'(WORD_BYTES);
          lenR  <= lenR - LEN_W'(1);
        end else if (selWr && !locked) begin
          if (regIdx[1:0] == 2'd0) addrR <= regWrData[ADDR_W-1:0];
          if (regIdx[1:0] == 2'd1) lenR  <= regWrData[LEN_W-1:0];
        end
        if (abort) begin
          armedR <= 1'b0;
        end else if (strobe.complete && isAct) begin
          armedR <= 1'b0;
        end else if (selWr && !locked && regIdx[1:0] == 2'd2) begin
          armedR <= regWrData[0] && (lenR != '0);
        end
      end
    end

    assign addrQ[s]  = addrR;
    assign lenQ[s]   = lenR;
    assign armedQ[s] = armedR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSel <= 1'b0;
      enable <= 1'b0;
      doneQ  <= 1'b0;
      dataQ  <= '0;
    end else begin
      if (strobe.flip)    actSel <= ~actSel;
      if (ctlWr)          enable <= regWrData[0];
      if (strobe.capture) dataQ  <= perData;
      if (strobe.complete)                doneQ <= 1'b1;
      else if (ctlWr && regWrData[1])     doneQ <= 1'b0;
    end
  end

  assign memAddr  = addrQ[actSel];
  assign memWData = dataQ;
  assign armedAct = armedQ[actSel];
  assign armedOth = armedQ[~actSel];
  assign lastWord = (lenQ[actSel] == LEN_W'(1));
  assign irq      = doneQ;

  always_comb begin
    regRdData = '0;
    if (regIdx == CTL_IDX) begin
      regRdData = {28'd0, actSel, busy, doneQ, enable};
    end else if (!regIdx[3]) begin
      unique case (regIdx[1:0])
        2'd0:    regRdData = 32'(addrQ[regIdx[2]]);
        2'd1:    regRdData = 32'(lenQ[regIdx[2]]);
        2'd2:    regRdData = {31'd0, armedQ[regIdx[2]]};
        default: regRdData = '0;
      endcase
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !strobe.flip) |=> memAddr == $past(memAddr) + ADDR_W'(WORD_BYTES));  // R4

  AST_COMPLETE_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.complete |=> irq);  // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(ctlWr && regWrData[1])) |=> irq);  // R8

  AST_ABORT_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (armedQ == '0));  // R10

endmodule

// File: rtl/pp_dma_channel.sv
module pp_dma_channel
  import pp_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [3:0]        regIdx,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              perValid,
  input  logic [DATA_W-1:0] perData,
  output logic              perReady,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic              memAck,
  output logic              irq
);

  dpStrobe_t strobe;
  logic busy, enable, abort, armedAct, armedOth, lastWord;

  pp_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .abort(abort),
    .armedAct(armedAct), .armedOth(armedOth), .lastWord(lastWord),
    .perValid(perValid), .memAck(memAck), .strobe(strobe),
    .busy(busy), .perReady(perReady), .memReq(memReq)
  );

  pp_dma_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regIdx(regIdx),
    .regWrData(regWrData), .regRdData(regRdData), .perData(perData),
    .strobe(strobe), .busy(busy), .memAddr(memAddr), .memWData(memWData),
    .armedAct(armedAct), .armedOth(armedOth), .lastWord(lastWord),
    .enable(enable), .abort(abort), .irq(irq)
  );

endmodule

// File: tb/pp_dma_channel_test.sv
module pp_dma_channel_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [3:0]  regIdx = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        perValid = 1'b0;
  logic [31:0] perData = '0;
  logic        perReady, memReq, memAck, irq;
  logic [31:0] memAddr, memWData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  initial memAck = 1'b0;

  always #2 clk = ~clk;

  pp_dma_channel uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regIdx(regIdx),
    .regWrData(regWrData), .regRdData(regRdData), .perValid(perValid),
    .perData(perData), .perReady(perReady), .memReq(memReq),
    .memAddr(memAddr), .memWData(memWData), .memAck(memAck), .irq(irq)
  );

  localparam int NV = 4;
  localparam logic [31:0] V_ADDR [NV] = '{32'h0000_1000, 32'h0000_2000, 32'h0001_FFF8, 32'h0000_0040};
  localparam logic [31:0] V_LEN  [NV] = '{32'd3, 32'd1, 32'd4, 32'd2};
  localparam logic [31:0] V_SEED [NV] = '{32'hA5A5_0000, 32'h5A5A_0100, 32'hC3C3_0200, 32'h3C3C_0300};

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regIdx = idx; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    regIdx = idx;
    #1 d = regRdData;
  endtask

  task automatic offerWord(input logic [31:0] data);
    @(negedge clk);
    perValid = 1'b1; perData = data;
    #1;
    for (int n = 0; n < 50 && !perReady; n++) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    perValid = 1'b0;
    #1;
  endtask

  task automatic xferWord(input logic [31:0] data, input logic [31:0] expAddr);
    offerWord(data);
    chkEq("R4 memReq", {31'd0, memReq}, 32'd1);
    chkEq("R11 perReady low during memReq", {31'd0, perReady}, 32'd0);
    chkEq("R4 memAddr", memAddr, expAddr);
    chkEq("R4 memWData", memWData, data);
    memAck = 1'b1;
    @(negedge clk);
    memAck = 1'b0;
    #1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] rd;
    logic [3:0]  base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chkEq("R1 irq", {31'd0, irq}, 0);
    chkEq("R1 memReq", {31'd0, memReq}, 0);
    chkEq("R1 perReady", {31'd0, perReady}, 0);
    regRead(4'd8, rd); chkEq("R1 control", rd, 0);
    regRead(4'd2, rd); chkEq("R1 cmd0", rd, 0);
    regRead(4'd6, rd); chkEq("R1 cmd1", rd, 0);

    // R12 armed but disabled
    regWrite(4'd0, 32'h0000_0800);
    regWrite(4'd1, 32'd3);
    regWrite(4'd2, 32'd1);
    regRead(4'd2, rd); chkEq("R3 armed readback", rd, 1);
    repeat (5) @(negedge clk);
    #1 chkEq("R12 no start while disabled", {31'd0, perReady}, 0);
    regRead(4'd8, rd); chkEq("R12 busy clear", rd & 32'h4, 0);
    regWrite(4'd8, 32'd0);
    regRead(4'd2, rd); chkEq("R10 disable disarms", rd, 0);
    regWrite(4'd8, 32'd1);

    // R3 zero length does not arm
    regWrite(4'd1, 32'd0);
    regWrite(4'd2, 32'd1);
    regRead(4'd2, rd); chkEq("R3 zero length stays disarmed", rd, 0);
    #1 chkEq("R3 no start on zero length", {31'd0, perReady}, 0);

    // Table of transfers, alternating sets
    for (int i = 0; i < NV; i++) begin
      base = (i % 2 == 1) ? 4'd4 : 4'd0;
      regWrite(base, V_ADDR[i]);
      regWrite(base + 4'd1, V_LEN[i]);
      regWrite(base + 4'd2, 32'd1);
      for (int w = 0; w < int'(V_LEN[i]); w++)
        xferWord(V_SEED[i] + 32'(w), V_ADDR[i] + 32'(4 * w));
      chkEq("R5 irq after completion", {31'd0, irq}, 1);
      regRead(4'd8, rd);
      chkEq("R5 done bit", rd & 32'h2, 32'h2);
      chkEq("R7 idle after lone set", rd & 32'h4, 0);
      chkEq("R2 active set index", (rd >> 3) & 32'h1, 32'(i % 2));
      #1 chkEq("R7 perReady low when idle", {31'd0, perReady}, 0);
      regRead(base + 4'd2, rd); chkEq("R5 set disarmed", rd, 0);
      regRead(base, rd);        chkEq("R2 address readback", rd, V_ADDR[i] + 4 * V_LEN[i]);
      regRead(base + 4'd1, rd); chkEq("R2 count readback", rd, 0);
      regWrite(4'd8, 32'd3);
      #1 chkEq("R8 irq cleared", {31'd0, irq}, 0);
    end

    // R6 back-to-back hand-over (active set is 1, unarmed)
    regWrite(4'd0, 32'h0000_3000);
    regWrite(4'd1, 32'd2);
    regWrite(4'd2, 32'd1);
    regWrite(4'd4, 32'h0000_4000);
    regWrite(4'd5, 32'd1);
    regWrite(4'd6, 32'd1);
    regRead(4'd8, rd); chkEq("R6 set 0 active first", (rd >> 3) & 32'h1, 0);
    xferWord(32'h1111_0000, 32'h0000_3000);
    xferWord(32'h1111_0001, 32'h0000_3004);
    chkEq("R6 ready with no dead cycle", {31'd0, perReady}, 1);
    regIdx = 4'd8; #1;
    chkEq("R6 active set swapped", (regRdData >> 3) & 32'h1, 1);
    xferWord(32'h2222_0000, 32'h0000_4000);
    #1 chkEq("R7 idle after second set", {31'd0, perReady}, 0);

    // R8 sticky irq
    regWrite(4'd8, 32'd1);
    repeat (3) @(negedge clk);
    #1 chkEq("R8 irq held by write without clear bit", {31'd0, irq}, 1);
    regWrite(4'd8, 32'd3);
    #1 chkEq("R8 irq cleared by write-one", {31'd0, irq}, 0);

    // R9 writes to busy set ignored (active is 1, unarmed)
    regWrite(4'd0, 32'h0000_5000);
    regWrite(4'd1, 32'd2);
    regWrite(4'd2, 32'd1);
    regWrite(4'd0, 32'hDEAD_0000);
    regWrite(4'd1, 32'd9);
    regRead(4'd0, rd); chkEq("R9 active address locked", rd, 32'h0000_5000);
    regRead(4'd1, rd); chkEq("R9 active count locked", rd, 2);
    regWrite(4'd4, 32'h0000_6000);
    regRead(4'd4, rd); chkEq("R9 idle set writable", rd, 32'h0000_6000);
    regWrite(4'd5, 32'd1);
    regWrite(4'd6, 32'd1);

    // R10 abort with memory write pending
    offerWord(32'h7777_0000);
    chkEq("R10 memReq pending before abort", {31'd0, memReq}, 1);
    regWrite(4'd8, 32'd0);
    #1;
    chkEq("R10 memReq dropped", {31'd0, memReq}, 0);
    chkEq("R10 perReady dropped", {31'd0, perReady}, 0);
    regRead(4'd2, rd); chkEq("R10 set 0 disarmed", rd, 0);
    regRead(4'd6, rd); chkEq("R10 set 1 disarmed", rd, 0);
    regRead(4'd1, rd); chkEq("R10 count not stepped", rd, 2);
    chkEq("R10 no completion", {31'd0, irq}, 0);
    regWrite(4'd8, 32'd1);
    repeat (3) @(negedge clk);
    #1 chkEq("R10 stays idle after re-enable", {31'd0, perReady}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule